// File: doc/BRIEF.md
# Master-Filtered Region Write Guard

This block sits on the request path in front of a shared memory and decides, for every write, whether the issuing bus master may change the addressed location. Eight address windows can be programmed. Each window has an inclusive lower bound, an inclusive upper bound, an enable bit and a 32-bit allow mask. Bit `k` of the allow mask grants write permission to the master whose 5-bit identification tag equals `k`.

A write is refused when any enabled window that contains its address does not allow its master. In the same cycle, a refused write leaves the guard with its byte strobes forced to zero and returns an error flag to the requester. Reads, and writes that no window refuses, pass through unchanged. Write data does not pass through this block.

The first refusal records its address and master tag and raises a fault flag. Any further refusal only raises an overflow bit, until software clears the flag. A small word-addressed register port programs the windows and reads the fault record.

Top module: `region_write_guard`

## Requirements
- R1: After reset every window is disabled and reads back as zero, the fault flag, overflow bit, captured address and captured tag are zero, and every write passes unchanged.
- R2: A window contains an address when its enable bit (control word bit 0) is 1 and lower <= address <= upper, with both bounds inclusive. A window whose lower bound exceeds its upper bound contains nothing.
- R3: If a write (`s_req`=1, `s_we`=1) falls in a window whose allow-mask bit at index `s_mid` is 0, then in the same cycle `m_wstrb` is 0 and `s_err` is 1.
- R4: A write that no containing window refuses leaves with `m_wstrb` equal to `s_wstrb` and `s_err` 0. `m_req`, `m_we` and `m_addr` always equal their inputs.
- R5: A read (`s_we`=0) is never refused. Its strobes pass unchanged, `s_err` stays 0, and the fault record is not touched.
- R6: When windows overlap, a write is refused if at least one containing window refuses it, even if others allow it.
- R7: On a refusal while the fault flag is 0, the next clock sets the flag and captures the address and master tag.
- R8: On a refusal while the flag is 1, the next clock sets the overflow bit and leaves the captured address and tag unchanged.
- R9: Writing the status word with bit 0 set clears the flag and the overflow bit. A refusal in the same cycle is then captured as a first fault.
- R10: Register map (word index on `cfg_addr`). Window `i` occupies indices 4i+0 (lower bound), 4i+1 (upper bound), 4i+2 (allow mask) and 4i+3 (control, bit 0 = enable). Index 32 is status (bit 0 = fault flag, bit 1 = overflow), 33 is the captured address, and 34 is the captured tag in bits 4:0. Writes take effect on the next clock, and reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_req | input | 1 | Request valid from the bus |
| s_we | input | 1 | 1 = write, 0 = read |
| s_addr | input | 32 | Request address |
| s_mid | input | 5 | Master identification tag |
| s_wstrb | input | 4 | Byte write strobes |
| m_req | output | 1 | Request valid toward memory |
| m_we | output | 1 | Write flag toward memory |
| m_addr | output | 32 | Address toward memory |
| m_wstrb | output | 4 | Strobes toward memory, zero when refused |
| s_err | output | 1 | Error response for a refused write |
| cfg_wr | input | 1 | Register write enable |
| cfg_addr | input | 6 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data |

## Verification
The refusal decision is combinational. For each bus request, `m_wstrb` and `s_err` are sampled 1 ns after the inputs are driven at a falling edge, so they are checked before the next rising edge. Changes to the fault record and to window settings appear one rising edge later. The bench therefore reads the status words only after that edge, through the combinational read port. A bench reference model is updated at the same edge and gives the expected values. Random windows over a 256-byte range produce frequent hits and overlaps. Directed cases cover both inclusive bounds, inverted bounds, reads into protected windows, overlap priority and a clear that coincides with a refusal.

// File: rtl/rwg_pkg.sv
package rwg_pkg;
    localparam int NREG  = 8;
    localparam int AW    = 32;
    localparam int MIDW  = 5;
    localparam int SW    = 4;
    localparam int DW    = 32;
    localparam int MASKW = 1 << MIDW;
    localparam int RIW   = $clog2(NREG);
    localparam int CAW   = RIW + 3;

    typedef enum logic [1:0] {
        FLD_LO   = 2'd0,
        FLD_HI   = 2'd1,
        FLD_MASK = 2'd2,
        FLD_CTRL = 2'd3
    } win_field_e;

    typedef enum logic [1:0] {
        ST_FLAGS = 2'd0,
        ST_ADDR  = 2'd1,
        ST_MID   = 2'd2,
        ST_NONE  = 2'd3
    } stat_field_e;

    typedef struct packed {
        logic             en;
        logic [AW-1:0]    lo;
        logic [AW-1:0]    hi;
        logic [MASKW-1:0] allow;
    } win_cfg_t;

    function automatic logic win_contains(win_cfg_t w, logic [AW-1:0] a);
        return w.en && (a >= w.lo) && (a <= w.hi);
    endfunction
endpackage

// File: rtl/rwg_window_bank.sv
module rwg_window_bank
    import rwg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_wr,
    input  logic [CAW-1:0]       cfg_addr,
    input  logic [DW-1:0]        cfg_wdata,
    output win_cfg_t [NREG-1:0]  win_o
);
    logic       win_space;
    logic [1:0] fld;
    assign win_space = ~cfg_addr[CAW-1];
    assign fld       = cfg_addr[1:0];

    for (genvar i = 0; i < NREG; i++) begin : g_win
        logic sel;
        assign sel = cfg_wr && win_space && (cfg_addr[CAW-2:2] == RIW'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                win_o[i] <= '0;
            end else if (sel) begin
                case (win_field_e'(fld))
                    FLD_LO:   win_o[i].lo    <= cfg_wdata[AW-1:0];
                    FLD_HI:   win_o[i].hi    <= cfg_wdata[AW-1:0];
                    FLD_MASK: win_o[i].allow <= cfg_wdata[MASKW-1:0];
                    default:  win_o[i].en    <= cfg_wdata[0];
                endcase
            end
        end
    end
endmodule

// File: rtl/rwg_hit_check.sv
module rwg_hit_check
    import rwg_pkg::*;
(
    input  win_cfg_t [NREG-1:0] win_i,
    input  logic [AW-1:0]       addr_i,
    input  logic [MIDW-1:0]     mid_i,
    output logic [NREG-1:0]     hit_o,
    output logic                deny_o
);
    logic [NREG-1:0] deny_v;

    for (genvar i = 0; i < NREG; i++) begin : g_cmp
        assign hit_o[i]  = win_contains(win_i[i], addr_i);
        assign deny_v[i] = hit_o[i] && !win_i[i].allow[mid_i];
    end

    assign deny_o = |deny_v;
endmodule

// File: rtl/rwg_fault_log.sv
module rwg_fault_log
    import rwg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            evt_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [MIDW-1:0] mid_i,
    input  logic            clr_i,
    output logic            flag_o,
    output logic            ovf_o,
    output logic [AW-1:0]   cap_addr_o,
    output logic [MIDW-1:0] cap_mid_o
);
    logic fresh;
    assign fresh = !flag_o || clr_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_o     <= 1'b0;
            ovf_o      <= 1'b0;
            cap_addr_o <= '0;
            cap_mid_o  <= '0;
        end else begin
            if (clr_i) begin
                flag_o <= 1'b0;
                ovf_o  <= 1'b0;
            end
            if (evt_i) begin
                if (fresh) begin
                    flag_o     <= 1'b1;
                    cap_addr_o <= addr_i;
                    cap_mid_o  <= mid_i;
                end else begin
                    ovf_o <= 1'b1;
                end
            end
        end
    end

    // R7
    flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_o) |-> $past(evt_i));

    // R8
    capture_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_o && $past(flag_o) && !$past(clr_i)) |-> ($stable(cap_addr_o) && $stable(cap_mid_o)));

    // R8
    ovf_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> flag_o);
endmodule

// File: rtl/region_write_guard.sv
module region_write_guard
    import rwg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            s_req,
    input  logic            s_we,
    input  logic [AW-1:0]   s_addr,
    input  logic [MIDW-1:0] s_mid,
    input  logic [SW-1:0]   s_wstrb,
    output logic            m_req,
    output logic            m_we,
    output logic [AW-1:0]   m_addr,
    output logic [SW-1:0]   m_wstrb,
    output logic            s_err,
    input  logic            cfg_wr,
    input  logic [CAW-1:0]  cfg_addr,
    input  logic [DW-1:0]   cfg_wdata,
    output logic [DW-1:0]   cfg_rdata
);
    win_cfg_t [NREG-1:0] win;
    logic [NREG-1:0]     hit;
    logic                deny;
    logic                refuse;
    logic                clr;
    logic                flag, ovf;
    logic [AW-1:0]       cap_addr;
    logic [MIDW-1:0]     cap_mid;

    rwg_window_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .win_o     (win)
    );

    rwg_hit_check u_hit (
        .win_i  (win),
        .addr_i (s_addr),
        .mid_i  (s_mid),
        .hit_o  (hit),
        .deny_o (deny)
    );

    assign refuse  = s_req && s_we && deny;
    assign m_req   = s_req;
    assign m_we    = s_we;
    assign m_addr  = s_addr;
    assign m_wstrb = refuse ? '0 : s_wstrb;
    assign s_err   = refuse;

    assign clr = cfg_wr && cfg_addr[CAW-1] && (cfg_addr[1:0] == ST_FLAGS) && cfg_wdata[0];

    rwg_fault_log u_log (
        .clk        (clk),
        .rst        (rst),
        .evt_i      (refuse),
        .addr_i     (s_addr),
        .mid_i      (s_mid),
        .clr_i      (clr),
        .flag_o     (flag),
        .ovf_o      (ovf),
        .cap_addr_o (cap_addr),
        .cap_mid_o  (cap_mid)
    );

    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr[CAW-1]) begin
            case (stat_field_e'(cfg_addr[1:0]))
                ST_FLAGS: cfg_rdata = {{(DW-2){1'b0}}, ovf, flag};
                ST_ADDR:  cfg_rdata = DW'(cap_addr);
                ST_MID:   cfg_rdata = DW'(cap_mid);
                default:  cfg_rdata = '0;
            endcase
        end else begin
            case (win_field_e'(cfg_addr[1:0]))
                FLD_LO:   cfg_rdata = DW'(win[cfg_addr[CAW-2:2]].lo);
                FLD_HI:   cfg_rdata = DW'(win[cfg_addr[CAW-2:2]].hi);
                FLD_MASK: cfg_rdata = DW'(win[cfg_addr[CAW-2:2]].allow);
                default:  cfg_rdata = DW'(win[cfg_addr[CAW-2:2]].en);
            endcase
        end
    end

    // R5
    read_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (s_req && !s_we) |-> (!s_err && m_wstrb == s_wstrb));

    // R3
    err_drops_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        s_err |-> (m_wstrb == '0 && s_we && (hit != '0)));

    // R4
    no_hit_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (s_req && hit == '0) |-> (!s_err && m_wstrb == s_wstrb));

    // R1
    reset_clean_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!flag && !ovf && hit == '0));
endmodule

// File: tb/region_write_guard_tb.sv
module region_write_guard_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        s_req, s_we;
    logic [31:0] s_addr;
    logic [4:0]  s_mid;
    logic [3:0]  s_wstrb;
    logic        m_req, m_we;
    logic [31:0] m_addr;
    logic [3:0]  m_wstrb;
    logic        s_err;
    logic        cfg_wr;
    logic [5:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] e_lo[8], e_hi[8], e_mask[8];
    logic        e_en[8];
    logic        e_flag, e_ovf;
    logic [31:0] e_caddr;
    logic [4:0]  e_cmid;

    always #5 clk = ~clk;

    region_write_guard u_dut (
        .clk(clk), .rst(rst),
        .s_req(s_req), .s_we(s_we), .s_addr(s_addr), .s_mid(s_mid), .s_wstrb(s_wstrb),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wstrb(m_wstrb), .s_err(s_err),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    function automatic logic exp_deny(logic [31:0] a, logic [4:0] m);
        logic d = 1'b0;
        for (int i = 0; i < 8; i++)
            if (e_en[i] && a >= e_lo[i] && a <= e_hi[i] && !e_mask[i][m]) d = 1'b1;
        return d;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        #1 cfg_wr = 1'b0;
        if (!a[5]) begin
            case (a[1:0])
                2'd0: e_lo[a[4:2]] = d;
                2'd1: e_hi[a[4:2]] = d;
                2'd2: e_mask[a[4:2]] = d;
                default: e_en[a[4:2]] = d[0];
            endcase
        end else if (a[1:0] == 2'd0 && d[0]) begin
            e_flag = 1'b0; e_ovf = 1'b0;
        end
    endtask

    task automatic cfg_read(logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic set_win(int i, logic [31:0] lo, logic [31:0] hi, logic [31:0] mask, logic en);
        cfg_write(6'(i*4+0), lo);
        cfg_write(6'(i*4+1), hi);
        cfg_write(6'(i*4+2), mask);
        cfg_write(6'(i*4+3), {31'd0, en});
    endtask

    task automatic model_event(logic [31:0] a, logic [4:0] m);
        if (!e_flag) begin
            e_flag = 1'b1; e_caddr = a; e_cmid = m;
        end else begin
            e_ovf = 1'b1;
        end
    endtask

    task automatic bus(string req, logic we, logic [31:0] a, logic [4:0] m, logic [3:0] st);
        logic d;
        @(negedge clk);
        s_req = 1'b1; s_we = we; s_addr = a; s_mid = m; s_wstrb = st;
        d = we && exp_deny(a, m);
        #1;
        check(req, {31'd0, s_err}, {31'd0, d});
        check(req, {28'd0, m_wstrb}, d ? 32'd0 : {28'd0, st});
        check("R4", {m_req, m_we, 30'd0} ^ {1'b1, we, 30'd0}, 32'd0);
        check("R4", m_addr, a);
        @(posedge clk);
        #1 s_req = 1'b0;
        if (d) model_event(a, m);
    endtask

    task automatic check_status(string req);
        logic [31:0] r;
        cfg_read(6'd32, r); check(req, r, {30'd0, e_ovf, e_flag});
        cfg_read(6'd33, r); check(req, r, e_caddr);
        cfg_read(6'd34, r); check(req, r, {27'd0, e_cmid});
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd1234));
        for (int i = 0; i < 8; i++) begin
            e_lo[i] = 0; e_hi[i] = 0; e_mask[i] = 0; e_en[i] = 0;
        end
        e_flag = 0; e_ovf = 0; e_caddr = 0; e_cmid = 0;
        rst = 1'b1; s_req = 0; s_we = 0; s_addr = 0; s_mid = 0; s_wstrb = 0;
        cfg_wr = 0; cfg_addr = 0; cfg_wdata = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        for (int a = 0; a < 32; a++) begin
            cfg_read(6'(a), r); check("R1", r, 32'd0);
        end
        check_status("R1");
        bus("R1", 1'b1, 32'h40, 5'd3, 4'hF);

        // R2 / R3: inclusive bounds, window 0 = [0x100,0x1FF], only master 2 allowed
        set_win(0, 32'h100, 32'h1FF, 32'h4, 1'b1);
        cfg_read(6'd0, r); check("R10", r, 32'h100);
        cfg_read(6'd2, r); check("R10", r, 32'h4);
        cfg_read(6'd3, r); check("R10", r, 32'h1);
        bus("R2", 1'b1, 32'hFF,  5'd7, 4'hF);
        bus("R3", 1'b1, 32'h100, 5'd7, 4'hA);
        check_status("R7");
        bus("R3", 1'b1, 32'h1FF, 5'd9, 4'h5);
        check_status("R8");
        bus("R2", 1'b1, 32'h200, 5'd7, 4'hF);
        bus("R4", 1'b1, 32'h150, 5'd2, 4'h3);
        // R5: read into protected window
        bus("R5", 1'b0, 32'h150, 5'd7, 4'hC);
        check_status("R5");

        // R9: clear, then clear coinciding with refusal
        cfg_write(6'd32, 32'h1);
        check_status("R9");
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 6'd32; cfg_wdata = 32'h1;
        s_req = 1'b1; s_we = 1'b1; s_addr = 32'h180; s_mid = 5'd1; s_wstrb = 4'hF;
        #1 check("R3", {31'd0, s_err}, 32'd1);
        @(posedge clk);
        #1 cfg_wr = 1'b0; s_req = 1'b0;
        model_event(32'h180, 5'd1);
        model_event(32'h190, 5'd1);
        bus("R8", 1'b1, 32'h190, 5'd1, 4'hF);
        check_status("R9");
        cfg_write(6'd32, 32'h1);

        // R6: overlap, window 1 covers 0x180..0x2FF allowing master 7 and 2
        set_win(1, 32'h180, 32'h2FF, 32'h84, 1'b1);
        bus("R6", 1'b1, 32'h1A0, 5'd7, 4'hF);
        bus("R6", 1'b1, 32'h1A0, 5'd2, 4'hF);
        bus("R6", 1'b1, 32'h250, 5'd7, 4'hF);
        // R2: inverted bounds contain nothing
        set_win(2, 32'h300, 32'h2FF, 32'h0, 1'b1);
        bus("R2", 1'b1, 32'h300, 5'd0, 4'hF);
        bus("R2", 1'b1, 32'h2FF, 5'd0, 4'hF);
        // R2: disabled window ignored
        set_win(1, 32'h180, 32'h2FF, 32'h84, 1'b0);
        bus("R2", 1'b1, 32'h250, 5'd0, 4'hF);
        check_status("R7");
        cfg_write(6'd32, 32'h1);

        // Random: windows over 0..255
        for (int round = 0; round < 20; round++) begin
            for (int i = 0; i < 8; i++) begin
                logic [31:0] lo = $urandom_range(0, 255);
                logic [31:0] hi = $urandom_range(0, 255);
                set_win(i, lo, hi, $urandom, 1'($urandom));
            end
            for (int k = 0; k < 40; k++) begin
                bus("R6", 1'($urandom), 32'($urandom_range(0, 255)), 5'($urandom), 4'($urandom));
                if (k % 10 == 9) check_status("R8");
                if ($urandom_range(0, 15) == 0) cfg_write(6'd32, 32'h1);
            end
            cfg_read(6'(4*(round % 8) + 1), r);
            check("R10", r, e_hi[round % 8]);
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule